// File: doc/BRIEF.md
# Synchronous Serial Port Register Front-End

This block is the register-facing side of a synchronous serial port. Software reaches it through a small register port with two addresses. One is a four-bit control word. It turns the port on, picks master or slave role, loops the port's own output back into its input, and can silence the data line when the port is a slave. The other is a data window. A write to the data window queues a word for sending. A read from it takes the oldest word that has been received.

Writes land in an eight-entry transmit FIFO. Whenever the port is enabled, the shift engine is idle and a word is queued, the front-end pops that word and hands it to the shift engine. When the engine signals the end of a frame, the received word is stored in an eight-entry receive FIFO. The engine here is a stub that models one frame as a fixed number of cycles. Before a frame is received, a multiplexer picks its source: the port's own outgoing word in loopback, or the external input word otherwise.

A frame-size input sets a frame length of 4 to 16 bits. Outgoing and incoming words are both cut to that length, and reads return them right-justified with zeros above. The block also decodes the control word into output enables for the clock/select lines and for the data line.

Top module: `sport_front`

## Requirements
- R1: After reset, all control bits are 0. A read of either address returns 0. tx_not_full is 1, rx_not_empty is 0, and ser_out_oe, clk_oe and ser_out_word are 0.
- R2: A write to address 0 sets the control word. Bit 0 is loopback, bit 1 is enable, bit 2 is role (1 = slave) and bit 3 is slave output off. A read of address 0 returns these four bits with bits 31:4 at 0.
- R3: A write to address 0 changes the role bit only if the enable bit was 0 before that write. The other three bits are always taken from the write.
- R4: From the edge that writes the control word, clk_oe equals enable AND NOT role. ser_out_oe equals enable AND (NOT role OR NOT output-off).
- R5: While enable is 0, no frame starts and nothing enters the receive FIFO. Clearing enable during a frame abandons that frame, and it never reaches the receive FIFO.
- R6: A write to address 1 pushes reg_wdata into an 8-entry transmit FIFO. tx_not_full is 0 while 8 words are held. A write made while tx_not_full is 0 is discarded.
- R7: Queued words are sent in write order. With the port enabled and the engine idle, a word written to an empty FIFO appears on ser_out_word one edge after the write edge. Its received word raises rx_not_empty FRAME_CYC+2 edges after the write edge.
- R8: A read of address 1 returns the oldest receive entry on reg_rdata one edge later and removes that entry. A read made while the receive FIFO is empty returns 0 and removes nothing.
- R9: frame_size value n gives a frame length of n+1 bits, and values 0 to 2 give 4 bits. The sent word and the stored received word are both masked to that length. Read data has zeros above the frame length, and bits 31:16 are always 0.
- R10: With loopback 1, the received word is the port's own ser_out_word. With loopback 0, it is ext_rx_word as sampled at the end of the frame.
- R11: A frame that completes while the receive FIFO holds 8 entries is discarded. The 8 stored entries are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = control word, 1 = data window |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| frame_size | input | 4 | Frame length code (length = code+1, minimum 4) |
| ext_rx_word | input | 16 | Word received from the external input line |
| ser_out_word | output | 16 | Word currently being sent |
| ser_out_oe | output | 1 | Drive enable for the outgoing data line |
| clk_oe | output | 1 | Drive enable for clock and select lines (master) |
| tx_not_full | output | 1 | Transmit FIFO can accept a word |
| rx_not_empty | output | 1 | Receive FIFO holds a word |

## Verification
Control writes, the two output enables and the FIFO flags all change on the write edge itself. The bench therefore checks them half a cycle after that edge. Read data is registered, so it is sampled on the falling edge that follows the read edge. In every vector the bench checks ser_out_word one edge after the data write. It checks that rx_not_empty is still low FRAME_CYC+1 edges after the write and high one edge after that, so the full frame latency is pinned exactly. Each frame takes FRAME_CYC+1 cycles, so the full-FIFO tests wait well past eight frames before reading.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef struct packed {
    logic sod;   // bit 3: slave output off
    logic ms;    // bit 2: role, 1 = slave
    logic en;    // bit 1: enable
    logic lbm;   // bit 0: loopback
  } sport_ctrl_t;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [3:0]  wdata,
  output sport_ctrl_t ctrl_q,
  output logic        clk_oe,
  output logic        ser_out_oe
);
  sport_ctrl_t nxt;

  always_comb begin
    nxt = ctrl_q;
    if (wr) begin
      nxt.lbm = wdata[0];
      nxt.en  = wdata[1];
      nxt.ms  = ctrl_q.en ? ctrl_q.ms : wdata[2];
      nxt.sod = wdata[3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      clk_oe     <= 1'b0;
      ser_out_oe <= 1'b0;
    end else begin
      ctrl_q     <= nxt;
      clk_oe     <= nxt.en && !nxt.ms;
      ser_out_oe <= nxt.en && (!nxt.ms || !nxt.sod);
    end
  end
endmodule

// File: rtl/sport_engine.sv
module sport_engine #(
  parameter int DW        = 16,
  parameter int FRAME_CYC = 4,
  localparam int CW       = $clog2(FRAME_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  logic [DW-1:0] rx_in,
  output logic          busy,
  output logic [DW-1:0] out_word,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      out_word <= '0;
      done     <= 1'b0;
      rx_word  <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (cnt == CW'(FRAME_CYC - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_word <= rx_in;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (start) begin
        busy     <= 1'b1;
        cnt      <= '0;
        out_word <= tx_word;
      end
    end
  end
endmodule

// File: rtl/sport_front.sv
module sport_front
  import sport_pkg::*;
#(
  parameter int DW        = 16,
  parameter int RW        = 32,
  parameter int DEPTH     = 8,
  parameter int FRAME_CYC = 4,
  localparam int FSW      = $clog2(DW),
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic [FSW-1:0] frame_size,
  input  logic [DW-1:0] ext_rx_word,
  output logic [DW-1:0] ser_out_word,
  output logic          ser_out_oe,
  output logic          clk_oe,
  output logic          tx_not_full,
  output logic          rx_not_empty
);
  sport_ctrl_t   ctrl;
  logic [FSW:0]  flen;
  logic [DW-1:0] mask;
  logic [DW-1:0] tx_head, rx_head, eng_rx_word, rx_src;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_push, tx_pop, rx_pop, rx_empty;
  logic          eng_busy, eng_done;

  // frame length and mask
  assign flen = (frame_size < FSW'(3)) ? (FSW+1)'(4) : (FSW+1)'(frame_size) + 1'b1;
  assign mask = ~({DW{1'b1}} << flen);

  sport_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr && reg_addr == ADDR_CTRL),
    .wdata     (reg_wdata[3:0]),
    .ctrl_q    (ctrl),
    .clk_oe    (clk_oe),
    .ser_out_oe(ser_out_oe)
  );

  assign tx_push = reg_wr && reg_addr == ADDR_DATA;
  assign tx_pop  = ctrl.en && !eng_busy && (tx_count != '0);

  sport_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk      (clk),
    .rst      (rst),
    .push     (tx_push),
    .push_data(reg_wdata),
    .pop      (tx_pop),
    .head     (tx_head),
    .count    (tx_count)
  );

  // serial input routing: own output in loopback, pin otherwise
  assign rx_src = ctrl.lbm ? ser_out_word : ext_rx_word;

  sport_engine #(.DW(DW), .FRAME_CYC(FRAME_CYC)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl.en),
    .start   (tx_pop),
    .tx_word (tx_head & mask),
    .rx_in   (rx_src),
    .busy    (eng_busy),
    .out_word(ser_out_word),
    .done    (eng_done),
    .rx_word (eng_rx_word)
  );

  assign rx_empty = (rx_count == '0);
  assign rx_pop   = reg_rd && reg_addr == ADDR_DATA && !rx_empty;

  sport_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk      (clk),
    .rst      (rst),
    .push     (eng_done),
    .push_data(eng_rx_word & mask),
    .pop      (rx_pop),
    .head     (rx_head),
    .count    (rx_count)
  );

  assign tx_not_full  = (tx_count != CW'(DEPTH));
  assign rx_not_empty = !rx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (reg_addr == ADDR_CTRL) reg_rdata <= RW'(ctrl);
      else                       reg_rdata <= rx_empty ? '0 : RW'(rx_head);
    end
  end
endmodule

// File: rtl/sport_front_chk.sv
module sport_front_chk #(
  parameter int DW    = 16,
  parameter int RW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          ctrl_en,
  input logic          ctrl_ms,
  input logic          ctrl_sod,
  input logic          ser_out_oe,
  input logic          clk_oe,
  input logic          eng_busy,
  input logic [CW-1:0] tx_count,
  input logic          reg_rd,
  input logic          reg_addr,
  input logic          rx_empty,
  input logic [RW-1:0] reg_rdata
);
  p_ms_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_en |=> $stable(ctrl_ms));

  p_sod_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_ms && ctrl_sod) |-> !ser_out_oe);

  p_master_clk_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && !ctrl_ms) |-> (clk_oe && ser_out_oe));

  p_off_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !eng_busy);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    tx_count <= CW'(DEPTH));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr && rx_empty) |=> (reg_rdata == '0));

  p_zero_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata >> DW) == '0);
endmodule

bind sport_front sport_front_chk #(.DW(DW), .RW(RW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl_en   (ctrl.en),
  .ctrl_ms   (ctrl.ms),
  .ctrl_sod  (ctrl.sod),
  .ser_out_oe(ser_out_oe),
  .clk_oe    (clk_oe),
  .eng_busy  (eng_busy),
  .tx_count  (tx_count),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .rx_empty  (rx_empty),
  .reg_rdata (reg_rdata)
);

// File: tb/sport_front_tb.sv
`timescale 1ns/1ps
module sport_front_tb;
  localparam int FRAME_CYC = 4;
  localparam int NV = 8;
  // {loopback, frame_size, write word, external word}
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 4'd15, 16'hA5C3, 16'h1234},
    {1'b1, 4'd7,  16'hA5C3, 16'hFFFF},
    {1'b1, 4'd3,  16'hFFFF, 16'h0000},
    {1'b1, 4'd0,  16'h00FF, 16'h0000},
    {1'b0, 4'd15, 16'h1111, 16'hBEEF},
    {1'b0, 4'd11, 16'h0000, 16'hBEEF},
    {1'b0, 4'd4,  16'hFFFF, 16'h00FF},
    {1'b1, 4'd9,  16'h3C3C, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  frame_size = 4'd15;
  logic [15:0] ext_rx_word = '0;
  logic [15:0] ser_out_word;
  logic        ser_out_oe, clk_oe, tx_not_full, rx_not_empty;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  sport_front u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_size(frame_size),
    .ext_rx_word(ext_rx_word), .ser_out_word(ser_out_word), .ser_out_oe(ser_out_oe),
    .clk_oe(clk_oe), .tx_not_full(tx_not_full), .rx_not_empty(rx_not_empty)
  );

  function automatic logic [15:0] fmask(input logic [3:0] fs);
    int len = (fs < 3) ? 4 : int'(fs) + 1;
    return (len >= 16) ? 16'hFFFF : 16'((32'd1 << len) - 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] exp;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 tx_not_full", 32'(tx_not_full), 32'd1);
    chk("R1 rx_not_empty", 32'(rx_not_empty), 32'd0);
    chk("R1 oe", {30'd0, ser_out_oe, clk_oe}, 32'd0);
    chk("R1 ser_out_word", 32'(ser_out_word), 32'd0);
    rd(1'b0, v); chk("R1 ctrl read", v, 32'd0);
    rd(1'b1, v); chk("R1 data read", v, 32'd0);

    // R2 field layout, reserved bits read zero
    wr(1'b0, 16'hFFFB);
    rd(1'b0, v); chk("R2 ctrl fields", v, 32'h0000_000B);
    wr(1'b0, 16'h0000);

    // R4 output enables
    wr(1'b0, 16'h0002);
    chk("R4 master enables", {30'd0, ser_out_oe, clk_oe}, 32'd3);
    wr(1'b0, 16'h0000);
    wr(1'b0, 16'h0004);
    chk("R4 slave disabled", {30'd0, ser_out_oe, clk_oe}, 32'd0);
    wr(1'b0, 16'h000E);
    chk("R4 slave output off", {30'd0, ser_out_oe, clk_oe}, 32'd0);
    wr(1'b0, 16'h0006);
    chk("R4 slave drives data", {30'd0, ser_out_oe, clk_oe}, 32'd2);

    // R3 role locked while enabled
    wr(1'b0, 16'h0002);
    rd(1'b0, v); chk("R3 role held", v, 32'h6);
    wr(1'b0, 16'h0000);
    rd(1'b0, v); chk("R3 role held on disabling write", v, 32'h4);
    wr(1'b0, 16'h0000);
    rd(1'b0, v); chk("R3 role written when off", v, 32'h0);

    // vector walk: R7 timing, R9 masking, R10 source select
    for (int i = 0; i < NV; i++) begin
      logic        lb;
      logic [3:0]  fs;
      logic [15:0] wd, ex;
      {lb, fs, wd, ex} = VEC[i];
      frame_size  = fs;
      ext_rx_word = ex;
      wr(1'b0, {14'd0, 1'b1, lb});
      wr(1'b1, wd);
      @(negedge clk);
      chk($sformatf("R9 R7 ser_out_word v%0d", i), 32'(ser_out_word), 32'(wd & fmask(fs)));
      idle(FRAME_CYC);
      chk($sformatf("R7 not yet received v%0d", i), 32'(rx_not_empty), 32'd0);
      @(negedge clk);
      chk($sformatf("R7 received on time v%0d", i), 32'(rx_not_empty), 32'd1);
      exp = (lb ? wd : ex) & fmask(fs);
      rd(1'b1, v);
      chk($sformatf("R10 R9 rx word v%0d", i), v, 32'(exp));
    end
    frame_size  = 4'd15;
    ext_rx_word = 16'h0000;

    // R5 nothing sent while disabled; R6 full FIFO drops write
    wr(1'b0, 16'h0001);
    for (int i = 0; i < 9; i++) begin
      wr(1'b1, 16'hE000 + 16'(i));
      if (i == 7) chk("R6 full after 8", 32'(tx_not_full), 32'd0);
    end
    chk("R6 still full", 32'(tx_not_full), 32'd0);
    idle(20);
    chk("R5 no frame while off", 32'(rx_not_empty), 32'd0);
    wr(1'b0, 16'h0003);
    idle(60);
    for (int i = 0; i < 8; i++) begin
      rd(1'b1, v);
      chk($sformatf("R6 R7 order %0d", i), v, 32'hE000 + 32'(i));
    end
    rd(1'b1, v); chk("R6 dropped word absent", v, 32'd0);

    // R5 abandon a frame in progress
    wr(1'b1, 16'h5A5A);
    idle(2);
    wr(1'b0, 16'h0001);
    idle(20);
    chk("R5 abandoned frame", 32'(rx_not_empty), 32'd0);
    rd(1'b1, v); chk("R8 empty read zero", v, 32'd0);

    // R11 receive overflow discards newest frame
    wr(1'b0, 16'h0003);
    for (int i = 0; i < 8; i++) wr(1'b1, 16'hC000 + 16'(i));
    idle(60);
    wr(1'b1, 16'hDEAD);
    idle(20);
    for (int i = 0; i < 8; i++) begin
      rd(1'b1, v);
      chk($sformatf("R11 R8 kept entry %0d", i), v, 32'hC000 + 32'(i));
    end
    chk("R8 empty after pops", 32'(rx_not_empty), 32'd0);
    rd(1'b1, v); chk("R11 overflow frame dropped", v, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule